// File: doc/BRIEF.md
# Staggered DDR refresh sequencer

This block owns the refresh duty of a DDR SDRAM controller that drives four ranks. A down-counter paces the refresh interval and banks each expiry into a pending counter. Refreshes can therefore be postponed and issued later in a burst. While refreshes are owed, the block raises a request to the command arbiter. Once the owed count reaches a programmed posting limit, it also flags the request as urgent. The arbiter must then grant before any new access.

On a grant the block takes over the command pins. It first closes all banks with precharge-all commands, split over three groups of chip selects on consecutive cycles to limit peak supply current. After a programmable spacing it issues auto-refresh in the same three groups. It then keeps a busy flag raised until the refresh recovery time has elapsed. That time is the sum of a base field and an extension field, and the arbiter must not open a row while busy is high. The full three-group stagger runs even when fewer ranks are fitted.

When the system sleeps, an enable bit selects one of two behaviours. With the bit set, a single refresh goes to every rank at once while clock-enable drops, putting the memory in self-refresh. With the bit clear, refresh simply stops and the owed count is kept. All configuration inputs are expected to be stable before the first memory access.

Top module: `ddr_refresh_seq`

## Requirements
- R1: While reset is asserted and just after it, all four chip selects are high (inactive), cke is high, and ref_req, ref_urgent and refresh_busy are low.
- R2: The interval counter adds one owed refresh every cfg_interval clock cycles. The first one is visible on ref_req after the (cfg_interval+1)-th rising edge following reset release. ref_req is high whenever the block is idle, sleep_req is low and at least one refresh is owed.
- R3: ref_urgent is high exactly when ref_req is high and the owed count is at least cfg_post_limit.
- R4: cs_n bit i low selects rank i. Precharge-all is ras_n=0, cas_n=1, we_n=0, a10=1. After the edge that samples ref_gnt together with ref_req, precharge-all goes out on the next three cycles with cs_n = 4'b0110, then 4'b1101, then 4'b1011. That is ranks 0 and 3 first, then rank 1, then rank 2.
- R5: Exactly cfg_pre_dly cycles with every chip select high lie between the last precharge-all group and the first refresh group.
- R6: Auto-refresh is ras_n=0, cas_n=0, we_n=1, a10=0. It is issued on three consecutive cycles in the same group order as R4.
- R7: refresh_busy rises in the first precharge-all cycle. It falls max(cfg_rec_base+cfg_rec_ext, 1) cycles after the cycle of the last refresh group.
- R8: Each accepted grant removes one owed refresh. Postponed refreshes left over make ref_req high again as soon as the block is idle.
- R9: With cfg_sr_en=1, raising sleep_req in idle produces, one cycle later, a single refresh to all ranks (cs_n=4'b0000) in the same cycle that cke falls. cke then stays low with no commands until sleep_req falls, and cke and busy return high and low respectively one cycle after that.
- R10: With cfg_sr_en=0, raising sleep_req in idle stops all commands and holds cke high. The interval counter is frozen and the owed count is kept, so ref_req is high again one cycle after sleep_req falls.
- R11: A ref_gnt pulse while ref_req is low has no effect: no command is issued and refresh_busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | INTV_W | Refresh interval in cycles |
| cfg_post_limit | input | POST_W | Owed-refresh count that makes the request urgent |
| cfg_rec_base | input | REC_W | Base refresh recovery cycles |
| cfg_rec_ext | input | REC_W | Extended refresh recovery cycles |
| cfg_pre_dly | input | DLY_W | Idle cycles between precharge-all and refresh groups |
| cfg_sr_en | input | 1 | Sleep behaviour: 1 = self-refresh, 0 = no refresh |
| sleep_req | input | 1 | Level request to enter and stay in sleep |
| ref_gnt | input | 1 | Arbiter grant for the refresh sequence |
| ref_req | output | 1 | Refresh owed and block ready to run it |
| ref_urgent | output | 1 | Owed count has reached the posting limit |
| refresh_busy | output | 1 | Sequence, recovery or sleep in progress; activates blocked |
| cs_n | output | 4 | Active-low chip selects, bit i = rank i |
| ras_n | output | 1 | Row strobe command bit |
| cas_n | output | 1 | Column strobe command bit |
| we_n | output | 1 | Write enable command bit |
| cke | output | 1 | Clock enable |
| a10 | output | 1 | Address bit 10 (all-banks qualifier) |

## Verification
The bench builds the block with an 8-bit interval, a 3-bit owed counter, 5-bit recovery fields and a 3-bit precharge spacing. With these widths the interval can be set to 40 cycles, so several ticks and a posted backlog of two occur within a few hundred cycles. They also make the largest spacing (7) and the largest recovery (31+31, a carry into the sum's extra bit) cheap to reach next to the zero-spacing, zero-recovery case. The short interval also lets the no-refresh sleep outlast two intervals, which exposes a counter that keeps running.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

    localparam int CS_CNT  = 4;
    localparam int GRP_CNT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_GAP,
        ST_REF,
        ST_REC,
        ST_SRE,
        ST_SR,
        ST_NOREF
    } ref_state_e;

    typedef struct packed {
        logic [CS_CNT-1:0] cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              cke;
        logic              a10;
    } dram_pins_t;

    // Stagger order: ranks 0 and 3, then rank 1, then rank 2
    function automatic logic [CS_CNT-1:0] grp_select_n(input logic [1:0] grp);
        case (grp)
            2'd0:    return 4'b0110;
            2'd1:    return 4'b1101;
            default: return 4'b1011;
        endcase
    endfunction

endpackage

// File: rtl/ref_interval_ctr.sv
module ref_interval_ctr #(
    parameter int INTV_W = 16,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              take,
    input  logic              clear,
    input  logic [INTV_W-1:0] cfg_interval,
    output logic [POST_W-1:0] pend
);

    localparam logic [POST_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic [INTV_W-1:0] cnt;
        logic [POST_W-1:0] pend;
    } ctr_s;

    ctr_s st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (run) begin
            if (st_q.cnt <= INTV_W'(1)) begin
                st_d.cnt = cfg_interval;
                tick     = (st_q.cnt == INTV_W'(1));
            end else begin
                st_d.cnt = st_q.cnt - INTV_W'(1);
            end
        end
        if (clear) begin
            st_d.pend = '0;
        end else if (tick && !take) begin
            if (st_q.pend != PEND_MAX) begin
                st_d.pend = st_q.pend + POST_W'(1);
            end
        end else if (!tick && take) begin
            st_d.pend = st_q.pend - POST_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/ref_cmd_decode.sv
module ref_cmd_decode
    import ddr_ref_pkg::*;
(
    input  ref_state_e state,
    input  logic [1:0] grp,
    output dram_pins_t pins
);

    always_comb begin
        pins.cs_n  = '1;
        pins.ras_n = 1'b1;
        pins.cas_n = 1'b1;
        pins.we_n  = 1'b1;
        pins.cke   = 1'b1;
        pins.a10   = 1'b0;
        case (state)
            ST_PRE: begin
                pins.cs_n  = grp_select_n(grp);
                pins.ras_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.a10   = 1'b1;
            end
            ST_REF: begin
                pins.cs_n  = grp_select_n(grp);
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            ST_SRE: begin
                pins.cs_n  = '0;
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.cke   = 1'b0;
            end
            ST_SR: begin
                pins.cke   = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
    import ddr_ref_pkg::*;
#(
    parameter int INTV_W = 16,
    parameter int POST_W = 4,
    parameter int REC_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] cfg_interval,
    input  logic [POST_W-1:0] cfg_post_limit,
    input  logic [REC_W-1:0]  cfg_rec_base,
    input  logic [REC_W-1:0]  cfg_rec_ext,
    input  logic [DLY_W-1:0]  cfg_pre_dly,
    input  logic              cfg_sr_en,
    input  logic              sleep_req,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              refresh_busy,
    output logic [3:0]        cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              a10
);

    localparam int SUM_W = REC_W + 1;
    localparam int CNT_W = (SUM_W > DLY_W) ? SUM_W : DLY_W;
    localparam logic [1:0] LAST_GRP = 2'(GRP_CNT - 1);

    typedef struct packed {
        ref_state_e       st;
        logic [1:0]       grp;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [POST_W-1:0] pend;
    logic [SUM_W-1:0]  rec_sum;
    logic              take, clr_pend, ctr_run, idle;
    dram_pins_t        pins;

    assign rec_sum = SUM_W'(cfg_rec_base) + SUM_W'(cfg_rec_ext);
    assign idle    = (seq_q.st == ST_IDLE);
    assign ctr_run = !(seq_q.st inside {ST_SRE, ST_SR, ST_NOREF});

    ref_interval_ctr #(
        .INTV_W (INTV_W),
        .POST_W (POST_W)
    ) u_intv (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (ctr_run),
        .take         (take),
        .clear        (clr_pend),
        .cfg_interval (cfg_interval),
        .pend         (pend)
    );

    always_comb begin
        seq_d      = seq_q;
        take       = 1'b0;
        clr_pend   = 1'b0;
        ref_req    = idle && !sleep_req && (pend != '0);
        ref_urgent = ref_req && (pend >= cfg_post_limit);
        case (seq_q.st)
            ST_IDLE: begin
                if (sleep_req) begin
                    seq_d.st = cfg_sr_en ? ST_SRE : ST_NOREF;
                    clr_pend = cfg_sr_en;
                end else if (ref_req && ref_gnt) begin
                    seq_d.st  = ST_PRE;
                    seq_d.grp = 2'd0;
                    take      = 1'b1;
                end
            end
            ST_PRE: begin
                if (seq_q.grp == LAST_GRP) begin
                    seq_d.grp = 2'd0;
                    if (cfg_pre_dly == '0) begin
                        seq_d.st = ST_REF;
                    end else begin
                        seq_d.st  = ST_GAP;
                        seq_d.cnt = CNT_W'(cfg_pre_dly) - CNT_W'(1);
                    end
                end else begin
                    seq_d.grp = seq_q.grp + 2'd1;
                end
            end
            ST_GAP: begin
                if (seq_q.cnt == '0) seq_d.st = ST_REF;
                else                 seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            ST_REF: begin
                if (seq_q.grp == LAST_GRP) begin
                    seq_d.grp = 2'd0;
                    if (rec_sum <= SUM_W'(1)) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.st  = ST_REC;
                        seq_d.cnt = CNT_W'(rec_sum) - CNT_W'(2);
                    end
                end else begin
                    seq_d.grp = seq_q.grp + 2'd1;
                end
            end
            ST_REC: begin
                if (seq_q.cnt == '0) seq_d.st = ST_IDLE;
                else                 seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            ST_SRE: begin
                seq_d.st = ST_SR;
            end
            ST_SR, ST_NOREF: begin
                if (!sleep_req) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.grp <= 2'd0;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    ref_cmd_decode u_dec (
        .state (seq_q.st),
        .grp   (seq_q.grp),
        .pins  (pins)
    );

    assign refresh_busy = !idle;
    assign cs_n         = pins.cs_n;
    assign ras_n        = pins.ras_n;
    assign cas_n        = pins.cas_n;
    assign we_n         = pins.we_n;
    assign cke          = pins.cke;
    assign a10          = pins.a10;

endmodule

// File: rtl/ddr_refresh_seq_chk.sv
module ddr_refresh_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_req,
    input logic       ref_gnt,
    input logic       refresh_busy,
    input logic [3:0] cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       cke,
    input logic       a10
);

    logic is_pre, is_ref;
    assign is_pre = (cs_n != 4'hF) && !ras_n && cas_n && !we_n;
    assign is_ref = (cs_n != 4'hF) && !ras_n && !cas_n && we_n;

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> a10);  // R4

    AST_PRE_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && cs_n == 4'b0110) |=> (is_pre && cs_n == 4'b1101));  // R4

    AST_REF_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && cke && cs_n == 4'b1101) |=> (is_ref && cs_n == 4'b1011));  // R6

    AST_SR_ALL_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (is_ref && cs_n == 4'b0000));  // R9

    AST_CKE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> refresh_busy);  // R9

    AST_GNT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (refresh_busy && is_pre));  // R8

    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> !ref_req);  // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_busy |-> (cs_n == 4'hF && cke));  // R11

endmodule

bind ddr_refresh_seq ddr_refresh_seq_chk u_chk (.*);

// File: tb/ddr_refresh_seq_test.sv
`timescale 1ns/1ps
module ddr_refresh_seq_test;

    localparam int INTV_W = 8;
    localparam int POST_W = 3;
    localparam int REC_W  = 5;
    localparam int DLY_W  = 3;

    typedef struct {
        int         cyc;
        logic [3:0] cs_n;
        logic       ras_n, cas_n, we_n, cke, a10;
        string      tag;
    } cmd_item_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [INTV_W-1:0] cfg_interval;
    logic [POST_W-1:0] cfg_post_limit;
    logic [REC_W-1:0]  cfg_rec_base, cfg_rec_ext;
    logic [DLY_W-1:0]  cfg_pre_dly;
    logic              cfg_sr_en, sleep_req, ref_gnt;
    logic              ref_req, ref_urgent, refresh_busy;
    logic [3:0]        cs_n;
    logic              ras_n, cas_n, we_n, cke, a10;

    int        cyc;
    int        nchk = 0;
    int        nbad = 0;
    cmd_item_t exp_q[$];

    always #4 clk = ~clk;

    ddr_refresh_seq #(
        .INTV_W (INTV_W), .POST_W (POST_W), .REC_W (REC_W), .DLY_W (DLY_W)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_interval (cfg_interval), .cfg_post_limit (cfg_post_limit),
        .cfg_rec_base (cfg_rec_base), .cfg_rec_ext (cfg_rec_ext),
        .cfg_pre_dly (cfg_pre_dly), .cfg_sr_en (cfg_sr_en),
        .sleep_req (sleep_req), .ref_gnt (ref_gnt),
        .ref_req (ref_req), .ref_urgent (ref_urgent), .refresh_busy (refresh_busy),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .cke (cke), .a10 (a10)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s at cyc %0d: actual %h expected %h", tag, cyc, act, expv);
        end
    endtask

    task automatic push_cmd(input int c, input logic [3:0] cs, input logic r, input logic ca,
                            input logic w, input logic ck, input logic a, input string tag);
        cmd_item_t it;
        it.cyc = c; it.cs_n = cs; it.ras_n = r; it.cas_n = ca; it.we_n = w;
        it.cke = ck; it.a10 = a; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: every command seen on the pins must match the next expected item
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cs_n !== 4'hF) begin
            if (exp_q.size() == 0) begin
                nchk++;
                nbad++;
                $display("FAIL R11 unexpected command at cyc %0d: actual cs_n=%b expected none", cyc, cs_n);
            end else begin
                cmd_item_t it;
                it = exp_q.pop_front();
                chk(cyc == it.cyc && cs_n == it.cs_n && ras_n == it.ras_n && cas_n == it.cas_n &&
                    we_n == it.we_n && cke == it.cke && a10 == it.a10, it.tag,
                    {cyc[22:0], cs_n, ras_n, cas_n, we_n, cke, a10},
                    {it.cyc[22:0], it.cs_n, it.ras_n, it.cas_n, it.we_n, it.cke, it.a10});
            end
        end
    end

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Driver: grants a refresh and queues the expected staggered commands
    task automatic run_seq(input int dly, input int base, input int ext);
        int c, t, rm;
        cfg_pre_dly  = DLY_W'(dly);
        cfg_rec_base = REC_W'(base);
        cfg_rec_ext  = REC_W'(ext);
        c  = cyc;
        rm = (base + ext < 1) ? 1 : base + ext;
        push_cmd(c + 1, 4'b0110, 0, 1, 0, 1, 1, "R4");
        push_cmd(c + 2, 4'b1101, 0, 1, 0, 1, 1, "R4");
        push_cmd(c + 3, 4'b1011, 0, 1, 0, 1, 1, "R4");
        push_cmd(c + 4 + dly, 4'b0110, 0, 0, 1, 1, 0, "R5");
        push_cmd(c + 5 + dly, 4'b1101, 0, 0, 1, 1, 0, "R6");
        push_cmd(c + 6 + dly, 4'b1011, 0, 0, 1, 1, 0, "R6");
        t = c + 6 + dly;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk(refresh_busy == 1'b1, "R7 busy at first precharge", refresh_busy, 1);
        wait_cyc(t + rm - 1);
        chk(refresh_busy == 1'b1, "R7 busy last recovery cycle", refresh_busy, 1);
        wait_cyc(t + rm);
        chk(refresh_busy == 1'b0, "R7 busy released", refresh_busy, 0);
    endtask

    initial begin
        #1_600_000;
        nchk++;
        nbad++;
        $display("FAIL watchdog at cyc %0d: actual hung expected done", cyc);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int r;
        rst_n = 1'b0;
        cfg_interval = 8'd40; cfg_post_limit = 3'd2;
        cfg_rec_base = 5'd6;  cfg_rec_ext = 5'd3; cfg_pre_dly = 3'd2;
        cfg_sr_en = 1'b1; sleep_req = 1'b0; ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF && cke == 1'b1, "R1 pins idle in reset", {cs_n, cke}, {4'hF, 1'b1});
        chk(!ref_req && !ref_urgent && !refresh_busy, "R1 flags low in reset",
            {ref_req, ref_urgent, refresh_busy}, 0);
        rst_n = 1'b1;

        wait_cyc(10);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk(refresh_busy == 1'b0, "R11 stray grant ignored", refresh_busy, 0);

        wait_cyc(40);
        chk(ref_req == 1'b0, "R2 no request before interval", ref_req, 0);
        wait_cyc(41);
        chk(ref_req == 1'b1, "R2 request after interval", ref_req, 1);
        chk(ref_urgent == 1'b0, "R3 one owed below limit", ref_urgent, 0);
        wait_cyc(80);
        chk(ref_urgent == 1'b0, "R3 still below limit", ref_urgent, 0);
        wait_cyc(81);
        chk(ref_urgent == 1'b1, "R3 urgent at limit", ref_urgent, 1);

        run_seq(2, 6, 3);
        chk(ref_req == 1'b1 && ref_urgent == 1'b0, "R8 posted refresh still owed",
            {ref_req, ref_urgent}, 2'b10);
        run_seq(0, 0, 0);
        chk(ref_req == 1'b0, "R8 backlog drained", ref_req, 0);

        // Self-refresh sleep
        cfg_sr_en = 1'b1;
        sleep_req = 1'b1;
        push_cmd(cyc + 1, 4'b0000, 0, 0, 1, 0, 0, "R9");
        r = cyc;
        wait_cyc(r + 1);
        chk(cke == 1'b0 && refresh_busy == 1'b1, "R9 entry", {cke, refresh_busy}, 2'b01);
        wait_cyc(r + 95);
        chk(cke == 1'b0 && ref_req == 1'b0, "R9 cke held low", {cke, ref_req}, 0);
        sleep_req = 1'b0;
        wait_cyc(r + 96);
        chk(cke == 1'b1 && refresh_busy == 1'b0, "R9 exit", {cke, refresh_busy}, 2'b10);

        // No-refresh sleep
        while (!ref_req && cyc < r + 400) @(negedge clk);
        chk(ref_req == 1'b1, "R2 request after self-refresh", ref_req, 1);
        cfg_sr_en = 1'b0;
        sleep_req = 1'b1;
        r = cyc;
        wait_cyc(r + 1);
        chk(cke == 1'b1 && refresh_busy == 1'b1 && ref_req == 1'b0, "R10 entry",
            {cke, refresh_busy, ref_req}, 3'b110);
        wait_cyc(r + 100);
        chk(cke == 1'b1 && ref_req == 1'b0, "R10 quiet", {cke, ref_req}, 2'b10);
        sleep_req = 1'b0;
        wait_cyc(r + 101);
        chk(ref_req == 1'b1 && ref_urgent == 1'b0 && refresh_busy == 1'b0,
            "R10 owed kept, interval frozen", {ref_req, ref_urgent, refresh_busy}, 3'b100);

        run_seq(7, 31, 31);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected commands seen", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule